// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. When the valid strobe is high it compares two operands through five relations: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A 5-bit condition mask picks which relations count. The trap fires when at least one selected relation holds, so one mask can mix signed and unsigned tests.

A width-mode input selects one of two comparison widths. In word mode only the low half of each operand takes part, read as a 32-bit signed or unsigned value. In doubleword mode the full 64 bits take part. The decision is registered. The outputs are a one-cycle trap request, a program-exception subcause code for the exception entry logic downstream, and the set of relations that matched.

Top module: `trapcmp_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `trap_req` is 0, `trap_cause` is 0 and `trap_hits` is 0.
- R2: Mask bit 4 (value 0x10) selects "A less than B, signed". When it is set and the relation holds, the trap fires.
- R3: Mask bit 3 (value 0x08) selects "A greater than B, signed". When it is set and the relation holds, the trap fires.
- R4: Mask bit 2 (value 0x04) selects "A equals B". When it is set and the relation holds, the trap fires.
- R5: Mask bit 1 (value 0x02) selects "A less than B, unsigned". Mask bit 0 (value 0x01) selects "A greater than B, unsigned". When a selected relation holds, the trap fires.
- R6: With `wide_mode` = 0 (word mode), only bits 31:0 of each operand are compared, read as 32-bit signed or unsigned values. Bits 63:32 have no effect on the outputs.
- R7: With `wide_mode` = 1 (doubleword mode), all 64 bits are compared.
- R8: The outputs for an operation appear on the cycle after the one in which `op_valid` is sampled high, and they last one cycle. A cycle with `op_valid` low produces no trap on the next cycle.
- R9: A mask of 0x00 never traps. A mask of 0x1F always traps on a valid operation.
- R10: `trap_cause` is 4'h2 (the trap subcause) when `trap_req` is 1, and 4'h0 otherwise. `trap_hits` bit i is 1 only when mask bit i was set and its relation held. `trap_req` is 1 exactly when `trap_hits` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: evaluate the operands this cycle |
| op_a | input | 64 | First operand (A) |
| op_b | input | 64 | Second operand (B) |
| cond_mask | input | 5 | Condition mask (bit 4 lt signed, bit 3 gt signed, bit 2 eq, bit 1 lt unsigned, bit 0 gt unsigned) |
| wide_mode | input | 1 | 0 = compare low 32 bits, 1 = compare all 64 bits |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 4 | Program-exception subcause (4'h2 when trapping) |
| trap_hits | output | 5 | Selected relations that held, same bit layout as the mask |

## Verification
The only state is one output register. A wrong value in it appears on the ports on the cycle after the strobe and is replaced one cycle later. An error in any relation or in the width selection therefore shows as a wrong `trap_hits` bit on the very next cycle.

The directed cases pick operands that make each relation give a different answer. Negative against positive values split the signed and unsigned results. Operands that differ only in the upper half split word mode from doubleword mode. A wrong select or a swapped sign interpretation flips a specific hit bit.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;
    localparam int DATA_W   = 64;
    localparam int HALF_W   = DATA_W / 2;
    localparam int REL_N    = 5;
    localparam int CAUSE_W  = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h2;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'h0;

    // Bit positions of each relation in mask and hit vectors
    localparam int BIT_LTS = 4;
    localparam int BIT_GTS = 3;
    localparam int BIT_EQ  = 2;
    localparam int BIT_LTU = 1;
    localparam int BIT_GTU = 0;

    typedef struct packed {
        logic                req;
        logic [CAUSE_W-1:0]  cause;
        logic [REL_N-1:0]    hits;
    } trap_state_t;
endpackage

// File: rtl/trapcmp_relations.sv
module trapcmp_relations
    import trapcmp_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = HALF_W
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             wide,
    output logic [REL_N-1:0] rel
);
    localparam int XW = W + 1;

    logic [XW-1:0] sa, sb, ua, ub;

    // Extend to one extra bit so every compare can be done signed:
    // sign-extended forms give signed order, zero-extended forms unsigned.
    always_comb begin
        if (wide) begin
            sa = {a[W-1], a};
            sb = {b[W-1], b};
            ua = {1'b0, a};
            ub = {1'b0, b};
        end else begin
            sa = {{(XW-HW){a[HW-1]}}, a[HW-1:0]};
            sb = {{(XW-HW){b[HW-1]}}, b[HW-1:0]};
            ua = {{(XW-HW){1'b0}}, a[HW-1:0]};
            ub = {{(XW-HW){1'b0}}, b[HW-1:0]};
        end
    end

    always_comb begin
        rel          = '0;
        rel[BIT_LTS] = $signed(sa) < $signed(sb);
        rel[BIT_GTS] = $signed(sa) > $signed(sb);
        rel[BIT_EQ]  = ua == ub;
        rel[BIT_LTU] = $signed(ua) < $signed(ub);
        rel[BIT_GTU] = $signed(ua) > $signed(ub);
    end
endmodule

// File: rtl/trapcmp_select.sv
module trapcmp_select
    import trapcmp_pkg::*;
(
    input  logic [REL_N-1:0] rel,
    input  logic [REL_N-1:0] mask,
    output logic [REL_N-1:0] hits,
    output logic             fire
);
    for (genvar i = 0; i < REL_N; i++) begin : g_gate
        assign hits[i] = rel[i] & mask[i];
    end
    assign fire = |hits;
endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
    import trapcmp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [DW-1:0]       op_a,
    input  logic [DW-1:0]       op_b,
    input  logic [REL_N-1:0]    cond_mask,
    input  logic                wide_mode,
    output logic                trap_req,
    output logic [CAUSE_W-1:0]  trap_cause,
    output logic [REL_N-1:0]    trap_hits
);
    localparam int HW = DW / 2;

    logic [REL_N-1:0] rel;
    logic [REL_N-1:0] hits;
    logic             fire;
    trap_state_t      state_d, state_q;

    trapcmp_relations #(.W(DW), .HW(HW)) u_rel (
        .a    (op_a),
        .b    (op_b),
        .wide (wide_mode),
        .rel  (rel)
    );

    trapcmp_select u_sel (
        .rel  (rel),
        .mask (cond_mask),
        .hits (hits),
        .fire (fire)
    );

    always_comb begin
        state_d       = '0;
        state_d.cause = CAUSE_NONE;
        if (op_valid) begin
            state_d.hits = hits;
            state_d.req  = fire;
            if (fire) begin
                state_d.cause = CAUSE_TRAP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign trap_req   = state_q.req;
    assign trap_cause = state_q.cause;
    assign trap_hits  = state_q.hits;
endmodule

// File: rtl/trapcmp_chk.sv
module trapcmp_chk
    import trapcmp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [DW-1:0]      op_a,
    input logic [DW-1:0]      op_b,
    input logic [REL_N-1:0]   cond_mask,
    input logic               wide_mode,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [REL_N-1:0]   trap_hits
);
    logic seen_edge;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    // R8
    idle_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && !$past(op_valid) |-> !trap_req && trap_hits == '0);

    // R9
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && $past(cond_mask) == '0 |-> !trap_req);

    // R9
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && $past(op_valid) && $past(cond_mask) == 5'h1f |-> trap_req);

    // R10
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_cause == CAUSE_TRAP);

    // R10
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_cause == CAUSE_NONE);

    // R10
    hits_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> (trap_hits & ~$past(cond_mask)) == '0);

    // R4
    equal_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && $past(op_valid) && $past(cond_mask[BIT_EQ])
        && $past(op_a) == $past(op_b) |-> trap_hits[BIT_EQ]);
endmodule

bind trapcmp_unit trapcmp_chk #(.DW(DW)) u_trapcmp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .cond_mask  (cond_mask),
    .wide_mode  (wide_mode),
    .trap_req   (trap_req),
    .trap_cause (trap_cause),
    .trap_hits  (trap_hits)
);

// File: tb/trapcmp_unit_bench.sv
module trapcmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [4:0]  cond_mask = '0;
    logic        wide_mode = 1'b0;
    logic        trap_req;
    logic [3:0]  trap_cause;
    logic [4:0]  trap_hits;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    trapcmp_unit u_trapcmp_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .cond_mask  (cond_mask),
        .wide_mode  (wide_mode),
        .trap_req   (trap_req),
        .trap_cause (trap_cause),
        .trap_hits  (trap_hits)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected relation set written from the requirement text
    function automatic logic [4:0] rel_of(input logic [63:0] a, input logic [63:0] b, input logic w);
        logic [4:0] r;
        if (w) begin
            r[4] = $signed(a) < $signed(b);
            r[3] = $signed(a) > $signed(b);
            r[2] = a == b;
            r[1] = a < b;
            r[0] = a > b;
        end else begin
            r[4] = $signed(a[31:0]) < $signed(b[31:0]);
            r[3] = $signed(a[31:0]) > $signed(b[31:0]);
            r[2] = a[31:0] == b[31:0];
            r[1] = a[31:0] < b[31:0];
            r[0] = a[31:0] > b[31:0];
        end
        return r;
    endfunction

    // Drive one operation at a falling edge, check after the next rising edge,
    // then check the request has dropped one cycle later.
    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [4:0] m, input logic w);
        logic [4:0] eh;
        eh = rel_of(a, b, w) & m;
        op_a = a; op_b = b; cond_mask = m; wide_mode = w; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check(req, {15'd0, trap_req}, {15'd0, |eh});
        check(req, {11'd0, trap_hits}, {11'd0, eh});
        check("R10", {12'd0, trap_cause}, (|eh) ? 16'h2 : 16'h0);
        @(negedge clk);
        check("R8", {15'd0, trap_req}, 16'd0);
    endtask

    task automatic t_reset;
        check("R1", {15'd0, trap_req}, 16'd0);
        check("R1", {12'd0, trap_cause}, 16'd0);
        check("R1", {11'd0, trap_hits}, 16'd0);
    endtask

    task automatic t_single_bits;
        run_op("R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h10, 1'b1);
        run_op("R2", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h10, 1'b1);
        run_op("R3", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h08, 1'b1);
        run_op("R4", 64'h1234, 64'h1234, 5'h04, 1'b1);
        run_op("R4", 64'h1234, 64'h1235, 5'h04, 1'b1);
        run_op("R5", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1);
        run_op("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, 1'b1);
        run_op("R5", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h01, 1'b1);
    endtask

    task automatic t_widths;
        // R6: upper halves differ, low halves equal
        run_op("R6", 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b0);
        run_op("R7", 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b1);
        // R6: low word negative as 32-bit, positive as 64-bit
        run_op("R6", 64'h0000_0000_8000_0000, 64'd0, 5'h10, 1'b0);
        run_op("R7", 64'h0000_0000_8000_0000, 64'd0, 5'h10, 1'b1);
        run_op("R6", 64'h0000_0000_8000_0000, 64'd0, 5'h1b, 1'b0);
        run_op("R7", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 5'h1b, 1'b1);
    endtask

    task automatic t_mask_extremes;
        run_op("R9", 64'd3, 64'd7, 5'h00, 1'b1);
        run_op("R9", 64'd7, 64'd7, 5'h1f, 1'b1);
        run_op("R9", 64'h8000_0000_0000_0000, 64'd0, 5'h1f, 1'b0);
    endtask

    task automatic t_no_strobe;
        op_a = 64'd5; op_b = 64'd5; cond_mask = 5'h1f; op_valid = 1'b0;
        @(negedge clk);
        check("R8", {15'd0, trap_req}, 16'd0);
        check("R8", {11'd0, trap_hits}, 16'd0);
    endtask

    task automatic t_back_to_back;
        op_a = 64'd5; op_b = 64'd5; cond_mask = 5'h04; wide_mode = 1'b1; op_valid = 1'b1;
        @(negedge clk);
        check("R8", {15'd0, trap_req}, 16'd1);
        op_b = 64'd6;
        @(negedge clk);
        check("R8", {15'd0, trap_req}, 16'd0);
        op_valid = 1'b0;
        @(negedge clk);
        check("R8", {15'd0, trap_req}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bits();
        t_widths();
        t_mask_extremes();
        t_no_strobe();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule